// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between the bus side and the instruction decoder of a small processor core. It holds up to six instruction bytes that were read ahead of execution. It keeps the address of the next sequential fetch. When the queue has room, it asks the bus for one more 16-bit word. The returned word enters the queue as two bytes, the byte at the lower address first. The decoder sees the oldest byte together with a valid flag and takes it with a one-cycle pop.

Operand traffic from the execution unit always wins the bus, so prefetch requests are withheld while that traffic is pending. A taken branch uses the flush input. The flush empties the queue in one clock and reloads the fetch address. A word that was requested before the flush is thrown away when it returns. At most one fetch is outstanding at any time, and the returned data is signalled by a one-cycle acknowledge.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty: `count_o` = 0, `empty_o` = 1 and `head_valid_o` = 0. `fetch_addr_o` equals the parameter RESET_ADDR (default 0).
- R2: `fetch_req_o` is high only when at least BPF (2) byte slots are free, that is `count_o` <= DEPTH-2. It is high whenever that room exists and nothing else blocks it.
- R3: `fetch_req_o` is low in any cycle where `eu_bus_req_i` is high.
- R4: An accepted `fetch_ack_i` adds two bytes to the queue. `fetch_data_i[7:0]` is the byte at `fetch_addr`, and it leaves before `fetch_data_i[15:8]`, the byte at `fetch_addr`+1.
- R5: Each cycle with `fetch_req_o` high issues a fetch at the current `fetch_addr_o`. On the next clock `fetch_addr_o` advances by 2.
- R6: A pop while `head_valid_o` is high removes exactly one byte. A pop on an empty queue has no effect.
- R7: A push and a pop in the same cycle are both honoured, so the count changes by +1.
- R8: A flush leaves the queue empty on the next clock and loads `fetch_addr_o` from `flush_addr_i`. The acknowledge of a fetch issued before the flush adds no bytes.
- R9: Bytes are popped strictly in fetch-address order, starting from the reset or flush address.
- R10: `empty_o` is high exactly when `count_o` is 0, and `head_valid_o` is always the inverse of `empty_o`.
- R11: At most one fetch is outstanding. The cycle after a request, `fetch_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue and restart fetching |
| flush_addr_i | input | ADDR_W | New fetch address loaded by a flush |
| eu_bus_req_i | input | 1 | Execution unit wants the bus; blocks prefetch |
| fetch_req_o | output | 1 | Issue a word fetch at `fetch_addr_o` this cycle |
| fetch_addr_o | output | ADDR_W | Byte address of the next sequential fetch |
| fetch_ack_i | input | 1 | One-cycle strobe: fetched word on `fetch_data_i` |
| fetch_data_i | input | BPF*BYTE_W | Fetched word, lower-address byte in the low bits |
| head_valid_o | output | 1 | Oldest byte is present |
| head_byte_o | output | BYTE_W | Oldest byte |
| pop_i | input | 1 | Consume the oldest byte |
| count_o | output | $clog2(DEPTH+1) | Bytes held |
| empty_o | output | 1 | Queue holds no bytes |

## Verification
The assertions assume that the bus side behaves in three ways. It raises `fetch_ack_i` exactly once per issued request. It never raises it in the same cycle as the request. It never raises it with no request outstanding. Under these assumptions the one-outstanding and room rules can be stated against the ports alone. The bench's memory responder records each request's address and answers once, one or more cycles later. It keeps delivering a word that a flush has orphaned, so the discard path is exercised without ever creating an acknowledge that the block could not have caused.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
  // circular index step; depth need not be a power of two
  function automatic int unsigned wrap_idx(int unsigned base, int unsigned off,
                                           int unsigned depth);
    return (base + off) % depth;
  endfunction
endpackage

// File: rtl/fbq_store.sv
module fbq_store
  import fbq_pkg::*;
#(
  parameter int unsigned DEPTH  = 6,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BPF    = 2,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  push_i,
  input  logic [BPF*BYTE_W-1:0] data_i,
  input  logic                  pop_i,
  output logic [BYTE_W-1:0]     head_o,
  output logic [CNT_W-1:0]      count_o
);
  localparam logic [CNT_W-1:0] PUSH_N = CNT_W'(BPF);

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q, rd_d, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PTR_W-1:0]  lane_idx [BPF];
  logic              pop_ok;

  for (genvar k = 0; k < BPF; k++) begin : g_lane
    assign lane_idx[k] = PTR_W'(wrap_idx(int'(wr_q), k, DEPTH));
  end

  assign pop_ok = pop_i && (cnt_q != '0);

  always_comb begin
    rd_d  = pop_ok ? PTR_W'(wrap_idx(int'(rd_q), 1, DEPTH)) : rd_q;
    wr_d  = push_i ? PTR_W'(wrap_idx(int'(wr_q), BPF, DEPTH)) : wr_q;
    cnt_d = cnt_q + (push_i ? PUSH_N : '0) - (pop_ok ? CNT_W'(1) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) begin
      for (int k = 0; k < BPF; k++) mem_q[lane_idx[k]] <= data_i[k*BYTE_W +: BYTE_W];
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/fbq_fetch_ctl.sv
module fbq_fetch_ctl #(
  parameter int unsigned        ADDR_W     = 20,
  parameter int unsigned        BPF        = 2,
  parameter logic [ADDR_W-1:0]  RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              eu_req_i,
  input  logic              room_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              push_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BPF);

  logic              pend_q, stale_q;
  logic [ADDR_W-1:0] addr_q;

  // stale: a fetch issued before a flush is still due; its data is discarded
  assign req_o  = !pend_q && !stale_q && !flush_i && !eu_req_i && room_i;
  assign push_o = ack_i && pend_q && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
      addr_q  <= RESET_ADDR;
    end else if (flush_i) begin
      pend_q  <= 1'b0;
      stale_q <= (pend_q || stale_q) && !ack_i;
      addr_q  <= flush_addr_i;
    end else begin
      if (ack_i) begin
        if (stale_q) stale_q <= 1'b0;
        else         pend_q  <= 1'b0;
      end
      if (req_o) begin
        pend_q <= 1'b1;
        addr_q <= addr_q + STEP;
      end
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int unsigned       DEPTH      = 6,
  parameter int unsigned       ADDR_W     = 20,
  parameter int unsigned       BYTE_W     = 8,
  parameter int unsigned       BPF        = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned      CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic [ADDR_W-1:0]     flush_addr_i,
  input  logic                  eu_bus_req_i,
  output logic                  fetch_req_o,
  output logic [ADDR_W-1:0]     fetch_addr_o,
  input  logic                  fetch_ack_i,
  input  logic [BPF*BYTE_W-1:0] fetch_data_i,
  output logic                  head_valid_o,
  output logic [BYTE_W-1:0]     head_byte_o,
  input  logic                  pop_i,
  output logic [CNT_W-1:0]      count_o,
  output logic                  empty_o
);
  localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(DEPTH - BPF);

  logic [CNT_W-1:0] cnt;
  logic             push, room;

  assign room = (cnt <= ROOM_MAX);

  fbq_fetch_ctl #(
    .ADDR_W(ADDR_W), .BPF(BPF), .RESET_ADDR(RESET_ADDR)
  ) i_ctl (
    .clk_i, .rst_ni, .flush_i, .flush_addr_i,
    .eu_req_i(eu_bus_req_i), .room_i(room), .ack_i(fetch_ack_i),
    .req_o(fetch_req_o), .addr_o(fetch_addr_o), .push_o(push)
  );

  fbq_store #(
    .DEPTH(DEPTH), .BYTE_W(BYTE_W), .BPF(BPF)
  ) i_store (
    .clk_i, .rst_ni, .flush_i,
    .push_i(push), .data_i(fetch_data_i), .pop_i,
    .head_o(head_byte_o), .count_o(cnt)
  );

  assign count_o      = cnt;
  assign empty_o      = (cnt == '0);
  assign head_valid_o = !empty_o;
endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int unsigned  DEPTH  = 6,
  parameter int unsigned  ADDR_W = 20,
  parameter int unsigned  BPF    = 2,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic [ADDR_W-1:0] flush_addr_i,
  input logic              eu_bus_req_i,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_ack_i,
  input logic              pop_i,
  input logic              head_valid_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              empty_o
);
  // R2
  req_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> (count_o <= CNT_W'(DEPTH - BPF)));
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  // R3
  eu_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> !eu_bus_req_i);
  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |=> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(BPF)));
  // R6
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !fetch_ack_i && !flush_i) |=> empty_o);
  // R8
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0 && fetch_addr_o == $past(flush_addr_i)));
  // R10
  empty_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o == (count_o == '0)) && (head_valid_o == !empty_o));
  // R11
  one_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |=> !fetch_req_o);
endmodule

bind prefetch_queue prefetch_queue_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BPF(BPF)
) i_prefetch_queue_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
  .eu_bus_req_i(eu_bus_req_i), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
  .fetch_ack_i(fetch_ack_i), .pop_i(pop_i), .head_valid_o(head_valid_o),
  .count_o(count_o), .empty_o(empty_o)
);

// File: tb/test_prefetch_queue.sv
module test_prefetch_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;
  localparam int ADDR_W = 20;
  localparam int CW = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              flush_i = 1'b0;
  logic [ADDR_W-1:0] flush_addr_i = '0;
  logic              eu_bus_req_i = 1'b0;
  logic              fetch_req_o;
  logic [ADDR_W-1:0] fetch_addr_o;
  logic              fetch_ack_i = 1'b0;
  logic [15:0]       fetch_data_i = '0;
  logic              head_valid_o;
  logic [7:0]        head_byte_o;
  logic              pop_i = 1'b0;
  logic [CW-1:0]     count_o;
  logic              empty_o;

  int n_chk = 0, n_fail = 0;
  int lat = 1;
  bit r_pend = 0, r_drop = 0, ack_live = 0;
  int r_left = 0;
  logic [ADDR_W-1:0] r_addr = '0, exp_addr = '0;

  prefetch_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_prefetch_queue (
    .clk_i(clk), .rst_ni, .flush_i, .flush_addr_i, .eu_bus_req_i,
    .fetch_req_o, .fetch_addr_o, .fetch_ack_i, .fetch_data_i,
    .head_valid_o, .head_byte_o, .pop_i, .count_o, .empty_o
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] byte_at(logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'h3C ^ {a[11:8], a[15:12]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock; inputs already set by caller at the falling edge
  task automatic tick();
    logic [CW-1:0] c0;
    bit live, popd, fl;
    int expc;
    #1;
    c0 = count_o; live = fetch_ack_i && ack_live; popd = pop_i && head_valid_o; fl = flush_i;
    if (popd) begin
      chk(head_byte_o == byte_at(exp_addr), "R9 head byte", head_byte_o, byte_at(exp_addr));
      exp_addr = exp_addr + 1'b1;
    end
    if (fetch_req_o) begin
      r_pend = 1; r_addr = fetch_addr_o; r_left = lat; r_drop = 0;
    end
    if (fl && r_pend) r_drop = 1;
    @(posedge clk);
    @(negedge clk);
    expc = fl ? 0 : int'(c0) + (live ? 2 : 0) - (popd ? 1 : 0);
    chk(int'(count_o) == expc, fl ? "R8 count" : "R7 count", count_o, expc);
    chk(empty_o == (count_o == 0) && head_valid_o == !empty_o, "R10 flags",
        {empty_o, head_valid_o}, {count_o == 0, count_o != 0});
    fetch_ack_i = 1'b0; ack_live = 0;
    if (r_pend) begin
      if (r_left <= 1) begin
        fetch_ack_i = 1'b1;
        fetch_data_i = {byte_at(r_addr + 1'b1), byte_at(r_addr)};
        ack_live = !r_drop;
        r_pend = 0;
      end else r_left--;
    end
  endtask

  task automatic t_reset();
    eu_bus_req_i = 1'b1;
    #1;
    chk(count_o == 0 && empty_o && !head_valid_o, "R1 empty", count_o, 0);
    chk(fetch_addr_o == '0, "R1 addr", fetch_addr_o, 0);
    chk(!fetch_req_o, "R3 blocked", fetch_req_o, 0);
    eu_bus_req_i = 1'b0;
    #1;
    chk(fetch_req_o, "R2 request on room", fetch_req_o, 1);
  endtask

  task automatic t_fill();
    lat = 1;
    for (int i = 0; i < 10; i++) tick();
    chk(count_o == CW'(DEPTH), "R4 full count", count_o, DEPTH);
    chk(!fetch_req_o, "R2 no room", fetch_req_o, 0);
    chk(fetch_addr_o == 20'd6, "R5 addr", fetch_addr_o, 6);
  endtask

  task automatic t_drain();
    eu_bus_req_i = 1'b1; pop_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) tick();
    tick();  // pop on empty
    pop_i = 1'b0;
    chk(count_o == 0 && !head_valid_o, "R6 pop on empty", count_o, 0);
    chk(!fetch_req_o, "R3 eu priority", fetch_req_o, 0);
    chk(exp_addr == 20'd6, "R9 bytes drained", exp_addr, 6);
    eu_bus_req_i = 1'b0;
    #1;
    chk(fetch_req_o && fetch_addr_o == 20'd6, "R2 resume", fetch_addr_o, 6);
  endtask

  task automatic t_stream();
    lat = 2; pop_i = 1'b1;
    for (int i = 0; i < 60; i++) begin
      eu_bus_req_i = (i % 7 == 3);
      tick();
    end
    eu_bus_req_i = 1'b0; pop_i = 1'b0;
    chk(exp_addr > 20'd30, "R7 stream progress", exp_addr, 30);
  endtask

  task automatic t_flush();
    lat = 4;
    for (int i = 0; i < 12 && !r_pend; i++) tick();
    chk(r_pend, "R8 fetch in flight", r_pend, 1);
    flush_i = 1'b1; flush_addr_i = 20'h00123;
    tick();
    flush_i = 1'b0;
    exp_addr = 20'h00123;
    chk(count_o == 0 && fetch_addr_o == 20'h00123, "R8 flush", fetch_addr_o, 'h123);
    chk(!fetch_req_o, "R11 waits for orphan", fetch_req_o, 0);
    for (int i = 0; i < 30; i++) tick();
    chk(count_o == CW'(DEPTH), "R8 refill", count_o, DEPTH);
    eu_bus_req_i = 1'b1; pop_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) tick();
    pop_i = 1'b0; eu_bus_req_i = 1'b0;
    chk(exp_addr == 20'h00129, "R9 after flush", exp_addr, 'h129);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    eu_bus_req_i = 1'b0;
    t_fill();
    t_drain();
    t_stream();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule